// File: doc/BRIEF.md
# Dual-Channel Phase-Coherent Direct Digital Synthesizer Core

This block produces two digital cosine waveforms from one system clock. Each channel owns a 32-bit phase accumulator stepped by a frequency tuning word, a 14-bit phase offset, a quarter-wave cosine table and a 10-bit amplitude scaler. The result is one signed 10-bit sample per channel per clock. Because both channels share the clock and the same pipeline, equal settings on both channels give identical samples on every cycle.

Software-side logic loads tuning, offset and amplitude words for either channel through a parallel write port into shadow storage. An update strobe then arms a transfer. The transfer into the working registers happens only on the clock edge where a divide-by-four sync clock, which the block also drives out, rises. Offset and amplitude changes are delayed inside the pipeline so that a change to all three words shows up first on one and the same output sample.

Top module: `dds_dual_core`

## Requirements
- R1: While reset is active both output samples are 0 and the sync clock output is low.
- R2: After reset the sync clock output repeats the pattern low, low, high, high with a period of four system clocks, starting with two low cycles.
- R3: Each clock the active 32-bit tuning word is added modulo 2^32 into the channel's phase accumulator, starting from 0 after reset.
- R4: The 15-bit table phase is {acc[31:18] + offset (14 bits, carry discarded), acc[17]}; its top 10 bits L select the value trunc(511 * cos(2*pi*(L + 0.5)/1024)), truncated toward zero.
- R5: The output sample is (table value * amplitude) / 1024, truncated toward zero, with the amplitude an unsigned 10-bit word.
- R6: A write with select 0 loads the 32-bit tuning word, select 1 loads the offset from data bits [13:0], select 2 loads the amplitude from data bits [9:0] of the channel picked by the channel index; select 3 and data bits outside the field change nothing.
- R7: Written words stay in shadow storage and do not change any output until a transfer takes place.
- R8: A strobe sampled high on one edge arms a transfer; the shadow words are copied on the first later edge at which the sync clock rises, never earlier.
- R9: Tuning, offset and amplitude changes taken by one transfer reach the output on the same sample: the fourth edge after the transfer edge produces the first sample built from all three new words.
- R10: Two channels holding equal words since the same transfer produce equal samples on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write enable for the shadow words |
| wr_ch_i | input | 1 | Channel index of the write |
| wr_sel_i | input | 2 | Word select: 0 tuning, 1 offset, 2 amplitude, 3 none |
| wr_data_i | input | 32 | Write data |
| update_i | input | 1 | Transfer strobe |
| sync_clk_o | output | 1 | Divide-by-four sync clock |
| dout_o | output | 20 | Signed 10-bit samples, channel 0 in bits [9:0], channel 1 in [19:10] |

## Verification
A corrupted accumulator or offset shows at the ports four clocks later as a sample that leaves the cosine sequence a reference model predicts, and it stays wrong for every later sample because the accumulator never forgets. A transfer taken on the wrong edge shifts the whole new waveform by one or more clocks relative to the sync clock, so a per-cycle comparison catches it on the first affected sample. A latency mismatch between the three words shows as one transitional sample that mixes old and new settings.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [1:0] {
    SEL_FREQ  = 2'd0,
    SEL_PHASE = 2'd1,
    SEL_AMPL  = 2'd2,
    SEL_NONE  = 2'd3
  } wsel_e;
endpackage

// File: rtl/dds_sync_gen.sv
module dds_sync_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic update_i,
  output logic sync_clk_o,
  output logic apply_o
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] RISE_AT = CW'(DIV / 2 - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          rise_next;

  assign rise_next = (cnt_q == RISE_AT);
  assign apply_o   = pend_q & rise_next;

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    pend_d = update_i | (pend_q & ~apply_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign sync_clk_o = cnt_q[CW-1];
endmodule

// File: rtl/dds_param_bank.sv
module dds_param_bank
  import dds_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int ACC_W = 32,
  parameter int POW_W = 14,
  parameter int AMP_W = 10,
  parameter int CH_AW = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [CH_AW-1:0]            wr_ch_i,
  input  logic [1:0]                  wr_sel_i,
  input  logic [ACC_W-1:0]            wr_data_i,
  input  logic                        apply_i,
  output logic [NCH-1:0][ACC_W-1:0]   act_ftw_o,
  output logic [NCH-1:0][POW_W-1:0]   act_pow_o,
  output logic [NCH-1:0][AMP_W-1:0]   act_asf_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [ACC_W-1:0] sh_ftw_q, sh_ftw_d, ac_ftw_q;
    logic [POW_W-1:0] sh_pow_q, sh_pow_d, ac_pow_q;
    logic [AMP_W-1:0] sh_asf_q, sh_asf_d, ac_asf_q;
    logic             hit;

    assign hit = wr_en_i && (wr_ch_i == CH_AW'(c));

    always_comb begin
      sh_ftw_d = sh_ftw_q;
      sh_pow_d = sh_pow_q;
      sh_asf_d = sh_asf_q;
      if (hit) begin
        case (wsel_e'(wr_sel_i))
          SEL_FREQ:  sh_ftw_d = wr_data_i;
          SEL_PHASE: sh_pow_d = wr_data_i[POW_W-1:0];
          SEL_AMPL:  sh_asf_d = wr_data_i[AMP_W-1:0];
          default:   ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_ftw_q <= '0;
        sh_pow_q <= '0;
        sh_asf_q <= '0;
      end else if (hit) begin
        sh_ftw_q <= sh_ftw_d;
        sh_pow_q <= sh_pow_d;
        sh_asf_q <= sh_asf_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ac_ftw_q <= '0;
        ac_pow_q <= '0;
        ac_asf_q <= '0;
      end else if (apply_i) begin
        ac_ftw_q <= sh_ftw_q;
        ac_pow_q <= sh_pow_q;
        ac_asf_q <= sh_asf_q;
      end
    end

    assign act_ftw_o[c] = ac_ftw_q;
    assign act_pow_o[c] = ac_pow_q;
    assign act_asf_o[c] = ac_asf_q;
  end
endmodule

// File: rtl/dds_cos_lut.sv
module dds_cos_lut #(
  parameter int PH_W   = 15,
  parameter int LUT_AW = 10,
  parameter int AMP_W  = 10
) (
  input  logic [PH_W-1:0]          phase_i,
  output logic signed [AMP_W-1:0]  cos_o
);
  localparam int  QW      = LUT_AW - 2;
  localparam int  QN      = 1 << QW;
  localparam real PI      = 3.14159265358979323846;
  localparam real AMP_MAX = real'((1 << (AMP_W - 1)) - 1);

  logic [AMP_W-1:0] qtab [QN];

  for (genvar g = 0; g < QN; g++) begin : g_tab
    localparam int QV = $rtoi(AMP_MAX * $cos(2.0 * PI * (real'(g) + 0.5) / (4.0 * real'(QN))));
    assign qtab[g] = QV[AMP_W-1:0];
  end

  logic [LUT_AW-1:0] addr;
  logic [1:0]        quad;
  logic [QW-1:0]     idx;
  logic signed [AMP_W-1:0] mag;

  always_comb begin
    addr  = phase_i[PH_W-1 -: LUT_AW];
    quad  = addr[LUT_AW-1 -: 2];
    idx   = quad[0] ? ~addr[QW-1:0] : addr[QW-1:0];
    mag   = $signed(qtab[idx]);
    cos_o = (quad[0] ^ quad[1]) ? -mag : mag;
  end
endmodule

// File: rtl/dds_channel.sv
module dds_channel #(
  parameter int ACC_W  = 32,
  parameter int POW_W  = 14,
  parameter int LUT_AW = 10,
  parameter int AMP_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ACC_W-1:0]         ftw_i,
  input  logic [POW_W-1:0]         pow_i,
  input  logic [AMP_W-1:0]         asf_i,
  output logic signed [AMP_W-1:0]  out_o
);
  localparam int PH_W = POW_W + 1;
  localparam int PR_W = 2 * AMP_W + 1;
  localparam logic signed [PR_W-1:0] RND = PR_W'((1 << AMP_W) - 1);

  logic [ACC_W-1:0]        acc_q, acc_d;
  logic [POW_W-1:0]        pow_q, pow_d;
  logic [AMP_W-1:0]        asf1_q, asf2_q, asf3_q;
  logic [PH_W-1:0]         ph_q, ph_d;
  logic signed [AMP_W-1:0] cos_q, cos_d;
  logic signed [AMP_W-1:0] out_q, out_d;
  logic signed [PR_W-1:0]  prod, sum;
  logic [POW_W-1:0]        top_sum;

  dds_cos_lut #(.PH_W(PH_W), .LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_lut (
    .phase_i (ph_q),
    .cos_o   (cos_d)
  );

  always_comb begin
    acc_d   = acc_q + ftw_i;
    pow_d   = pow_i;
    top_sum = acc_q[ACC_W-1 -: POW_W] + pow_q;
    ph_d    = {top_sum, acc_q[ACC_W-POW_W-1]};
    prod    = cos_q * $signed({1'b0, asf3_q});
    sum     = prod + (prod[PR_W-1] ? RND : '0);
    out_d   = sum[AMP_W +: AMP_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pow_q  <= '0;
      asf1_q <= '0;
      asf2_q <= '0;
      asf3_q <= '0;
      ph_q   <= '0;
      cos_q  <= '0;
      out_q  <= '0;
    end else begin
      acc_q  <= acc_d;
      pow_q  <= pow_d;
      asf1_q <= asf_i;
      asf2_q <= asf1_q;
      asf3_q <= asf2_q;
      ph_q   <= ph_d;
      cos_q  <= cos_d;
      out_q  <= out_d;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/dds_dual_core.sv
module dds_dual_core #(
  parameter int NCH    = 2,
  parameter int ACC_W  = 32,
  parameter int POW_W  = 14,
  parameter int LUT_AW = 10,
  parameter int AMP_W  = 10,
  parameter int DIV    = 4,
  localparam int CH_AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [CH_AW-1:0]       wr_ch_i,
  input  logic [1:0]             wr_sel_i,
  input  logic [ACC_W-1:0]       wr_data_i,
  input  logic                   update_i,
  output logic                   sync_clk_o,
  output logic [NCH*AMP_W-1:0]   dout_o
);
  logic rst_m_q, rst_sync;
  logic apply;
  logic [NCH-1:0][ACC_W-1:0] act_ftw;
  logic [NCH-1:0][POW_W-1:0] act_pow;
  logic [NCH-1:0][AMP_W-1:0] act_asf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q  <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_m_q  <= 1'b1;
      rst_sync <= rst_m_q;
    end
  end

  dds_sync_gen #(.DIV(DIV)) u_sync (
    .clk        (clk),
    .rst_n      (rst_sync),
    .update_i   (update_i),
    .sync_clk_o (sync_clk_o),
    .apply_o    (apply)
  );

  dds_param_bank #(
    .NCH(NCH), .ACC_W(ACC_W), .POW_W(POW_W), .AMP_W(AMP_W), .CH_AW(CH_AW)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync),
    .wr_en_i   (wr_en_i),
    .wr_ch_i   (wr_ch_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .apply_i   (apply),
    .act_ftw_o (act_ftw),
    .act_pow_o (act_pow),
    .act_asf_o (act_asf)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic signed [AMP_W-1:0] smp;
    dds_channel #(
      .ACC_W(ACC_W), .POW_W(POW_W), .LUT_AW(LUT_AW), .AMP_W(AMP_W)
    ) u_ch (
      .clk   (clk),
      .rst_n (rst_sync),
      .ftw_i (act_ftw[c]),
      .pow_i (act_pow[c]),
      .asf_i (act_asf[c]),
      .out_o (smp)
    );
    assign dout_o[c*AMP_W +: AMP_W] = smp;
  end
endmodule

// File: rtl/dds_dual_core_chk.sv
module dds_dual_core_chk #(
  parameter int NCH   = 2,
  parameter int ACC_W = 32,
  parameter int AMP_W = 10
) (
  input logic                      clk,
  input logic                      rst_sync,
  input logic                      sync_clk,
  input logic                      apply,
  input logic [NCH-1:0][ACC_W-1:0] act_ftw,
  input logic [NCH*AMP_W-1:0]      dout
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_sync |-> (dout == '0 && !sync_clk)); // R1
  AST_SYNC_HOLD_HI: assert property (@(posedge clk) disable iff (!rst_sync) $rose(sync_clk) |=> sync_clk); // R2
  AST_SYNC_HOLD_LO: assert property (@(posedge clk) disable iff (!rst_sync) $fell(sync_clk) |=> !sync_clk); // R2
  AST_SYNC_PERIOD: assert property (@(posedge clk) disable iff (!rst_sync) (sync_clk && $past(sync_clk)) |=> !sync_clk); // R2
  AST_APPLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_sync) apply |=> $rose(sync_clk)); // R8
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync) !apply |=> $stable(act_ftw)); // R7
endmodule

bind dds_dual_core dds_dual_core_chk #(.NCH(NCH), .ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
  .clk      (clk),
  .rst_sync (rst_sync),
  .sync_clk (sync_clk_o),
  .apply    (apply),
  .act_ftw  (act_ftw),
  .dout     (dout_o)
);

// File: tb/sim_dds_dual_core.sv
module sim_dds_dual_core;
  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, upd;
  logic        wr_ch;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        sync_clk;
  logic [19:0] dout;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  dds_dual_core u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .update_i(upd), .sync_clk_o(sync_clk), .dout_o(dout)
  );

  always #5 clk = ~clk;

  // Reference model built from the requirement list
  logic [31:0] m_acc[2], m_sf[2], m_af[2];
  logic [13:0] m_sp[2], m_ap[2], m_pd[2], m_t;
  logic [9:0]  m_sa[2], m_aa[2], m_a1[2], m_a2[2], m_a3[2];
  logic [14:0] m_ph[2];
  int          m_c[2], m_o[2];
  bit          m_pend, ap, s_cur, s_prev;

  function automatic int cosv(logic [14:0] p);
    int l = int'(p[14:5]);
    return $rtoi(511.0 * $cos(2.0 * PI * (real'(l) + 0.5) / 1024.0));
  endfunction

  always @(negedge clk) begin
    s_prev <= s_cur;
    s_cur  <= sync_clk;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0;
      for (int c = 0; c < 2; c++) begin
        m_acc[c] = 0; m_sf[c] = 0; m_af[c] = 0; m_sp[c] = 0; m_ap[c] = 0; m_pd[c] = 0;
        m_sa[c] = 0; m_aa[c] = 0; m_a1[c] = 0; m_a2[c] = 0; m_a3[c] = 0;
        m_ph[c] = 0; m_c[c] = 0; m_o[c] = 0;
      end
    end else begin
      ap = m_pend && !s_cur && !s_prev;
      for (int c = 0; c < 2; c++) begin
        m_o[c]  = (m_c[c] * int'(m_a3[c])) / 1024;
        m_c[c]  = cosv(m_ph[c]);
        m_a3[c] = m_a2[c];
        m_t     = m_acc[c][31:18] + m_pd[c];
        m_ph[c] = {m_t, m_acc[c][17]};
        m_a2[c] = m_a1[c];
        m_acc[c] = m_acc[c] + m_af[c];
        m_pd[c] = m_ap[c];
        m_a1[c] = m_aa[c];
        if (ap) begin
          m_af[c] = m_sf[c]; m_ap[c] = m_sp[c]; m_aa[c] = m_sa[c];
        end
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_sf[wr_ch] = wr_data;
          2'd1: m_sp[wr_ch] = wr_data[13:0];
          2'd2: m_sa[wr_ch] = wr_data[9:0];
          default: ;
        endcase
      end
      m_pend = upd || (m_pend && !ap);
    end
  end

  function automatic int smp(int c);
    return int'($signed(dout[c*10 +: 10]));
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) chk(tag, smp(c), m_o[c]);
    end
  endtask

  task automatic wr(int ch, int sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_ch = ch[0]; wr_sel = sel[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_update();
    @(negedge clk);
    upd = 1;
    @(negedge clk);
    upd = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 out0", smp(0), 0);
    chk("R1 out1", smp(1), 0);
    chk("R1 sync", int'(sync_clk), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_sync();
    bit prev = sync_clk;
    int guard = 0;
    while (!(sync_clk && !prev) && guard < 20) begin
      prev = sync_clk;
      @(negedge clk);
      guard++;
    end
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      chk("R2 sync pattern", int'(sync_clk), ((i % 4) == 0 || (i % 4) == 1) ? 1 : 0);
    end
  endtask

  task automatic t_shadow();
    wr(0, 0, 32'h1000_0000);
    wr(0, 2, 32'd1023);
    wr(1, 0, 32'h0300_0000);
    wr(1, 2, 32'd700);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R7 no early effect", smp(0), 0);
      chk("R7 no early effect", smp(1), 0);
    end
  endtask

  task automatic t_apply();
    pulse_update();
    step(20, "R3 R4 R5 R8");
  endtask

  task automatic t_offset();
    wr(0, 1, 32'h0000_3FFF);
    wr(1, 0, 32'h0);
    wr(1, 1, 32'h0000_1000);
    wr(1, 2, 32'd511);
    pulse_update();
    step(16, "R4 offset");
  endtask

  task automatic t_amp();
    wr(0, 2, 32'd0);
    wr(1, 0, 32'h0755_1234);
    wr(1, 2, 32'd1023);
    pulse_update();
    step(16, "R5 scale");
  endtask

  task automatic t_latency();
    wr(0, 0, 32'h2222_0000);
    wr(0, 1, 32'h0000_0A00);
    wr(0, 2, 32'd333);
    pulse_update();
    step(12, "R9 matched latency");
  endtask

  task automatic t_ignore();
    int h0, h1;
    wr(0, 0, 32'h0);
    wr(0, 1, 32'hFFFF_C123);
    wr(0, 2, 32'hFFFF_FC40);
    wr(1, 0, 32'h0);
    pulse_update();
    step(10, "R6 fields");
    h0 = smp(0); h1 = smp(1);
    wr(0, 3, 32'h4000_0000);
    wr(1, 3, 32'h4000_0000);
    pulse_update();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R6 select 3 ignored", smp(0), h0);
      chk("R6 select 3 ignored", smp(1), h1);
    end
  endtask

  task automatic t_match();
    t_reset();
    for (int c = 0; c < 2; c++) begin
      wr(c, 0, 32'h0123_4567);
      wr(c, 1, 32'h0000_0ABC);
      wr(c, 2, 32'd777);
    end
    pulse_update();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R10 channels equal", smp(1), smp(0));
      chk("R10 model", smp(0), m_o[0]);
    end
  endtask

  task automatic t_wrap();
    wr(0, 0, 32'hC000_0000);
    wr(1, 0, 32'hFFFF_FFFF);
    wr(1, 2, 32'd1000);
    pulse_update();
    step(16, "R3 wrap");
  endtask

  initial begin
    rst_n = 0; wr_en = 0; upd = 0; wr_ch = 0; wr_sel = 0; wr_data = 0;
    t_reset();
    t_sync();
    t_shadow();
    t_apply();
    t_offset();
    t_amp();
    t_latency();
    t_ignore();
    t_match();
    t_wrap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog R1-to-end run actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule